// File: doc/BRIEF.md
# Opcode Fetch Detector and BRK Injector

This block watches the bus of a 65xx-family processor one CPU cycle at a time and works out, from the read/write direction alone, when a read is certainly the fetch of a new opcode. A store-type instruction does its only write in its last cycle, so a read that follows exactly one write, which was itself preceded by a read, must be an opcode fetch. Double writes (read-modify-write, subroutine call) and triple writes (interrupt entry) never match this pattern, so the block stays quiet on them.

When a freeze request has armed the block, it drives a pull-down on every data line for the whole of the matching read. The processor then fetches $00 and executes a BRK, which runs even with interrupts disabled. The end of that cycle raises a one-clock `injected` pulse, which enables the vector-redirect logic for the interrupt sequence that follows. One arm gives one injection. The block decodes no addresses and counts no instruction cycles.

The CPU cycle is presented on a fast system clock as two strobes: `cyc_mid`, at the point in the cycle where the direction line is valid, and `cyc_end`, at the end of the cycle. Cycles in which the processor does not own the bus are neither sampled nor entered into the history.

Top module: `ofd_brk_injector`

## Requirements
- R1: After reset, `dbus_pd` is all zeros, `injected` is 0 and the block is unarmed.
- R2: When armed, in an owned cycle whose `rnw` is 1 (read) at `cyc_mid`, and whose two previous owned cycles were a read (older) then a write (`rnw`=0), every bit of `dbus_pd` goes to 1 from the clock after `cyc_mid`.
- R3: A read that follows two consecutive writes does not drive `dbus_pd`.
- R4: A read that follows three consecutive writes does not drive `dbus_pd`.
- R5: `dbus_pd` returns to all zeros on the clock after `cyc_end`.
- R6: Each rising edge of `arm` allows exactly one injection; later matching reads are left alone until `arm` rises again.
- R7: While unarmed the bus is never driven, but the history still tracks cycles, so arming between a write and the following read still injects on that read.
- R8: A cycle with `bus_own` low is not sampled and does not shift the history, and is never driven; a read-write-(not owned)-read sequence still injects on the last read.
- R9: `injected` is high for exactly one clock, on the clock after the `cyc_end` of an injection cycle, and is otherwise 0.
- R10: After reset, no injection happens until two owned cycles have entered the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several periods per CPU cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_mid | input | 1 | One-clock strobe at the direction sampling point of a CPU cycle |
| cyc_end | input | 1 | One-clock strobe at the end of a CPU cycle |
| bus_own | input | 1 | 1 when the processor owns the bus in this cycle |
| rnw | input | 1 | Bus direction: 1 read, 0 write |
| arm | input | 1 | Freeze request; a rising edge arms one injection |
| dbus_pd | output | DATA_W | Per-line pull-down enable for the data bus |
| injected | output | 1 | One-clock pulse after the injection cycle ends |

## Verification
The hardest case to reach is a matching read pattern that is split by a cycle the processor does not own, together with the once-per-arm rule across repeated store patterns. The stimulus plays whole CPU cycles as strobe sequences, inserts a not-owned cycle between the write and the final read, replays the same store pattern after an injection without re-arming, and runs double and triple write bursts that must stay silent. A reference model of the history predicts each cycle's outcome and the scoreboard compares the pull-down during the cycle and the pulse after it.

// File: rtl/ofd_pkg.sv
package ofd_pkg;
  // Bus direction encoding on rnw
  localparam logic DIR_READ  = 1'b1;
  localparam logic DIR_WRITE = 1'b0;

  // History of the two most recent owned cycles
  typedef struct packed {
    logic vld_old;  // older entry filled
    logic rd_old;   // older entry was a read
    logic vld_new;  // newer entry filled
    logic rd_new;   // newer entry was a read
  } rw_hist_t;
endpackage

// File: rtl/ofd_rw_history.sv
module ofd_rw_history
  import ofd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cyc_mid,
  input  logic     cyc_end,
  input  logic     bus_own,
  input  logic     rnw,
  output rw_hist_t hist
);
  logic     cur_vld_q, cur_vld_d;
  logic     cur_rd_q,  cur_rd_d;
  rw_hist_t hist_q,    hist_d;

  always_comb begin
    cur_vld_d = cur_vld_q;
    cur_rd_d  = cur_rd_q;
    hist_d    = hist_q;
    if (cyc_mid && bus_own) begin
      cur_vld_d = 1'b1;
      cur_rd_d  = rnw;
    end
    if (cyc_end) begin
      cur_vld_d = 1'b0;
      if (cur_vld_q) begin
        hist_d.vld_old = hist_q.vld_new;
        hist_d.rd_old  = hist_q.rd_new;
        hist_d.vld_new = 1'b1;
        hist_d.rd_new  = cur_rd_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_vld_q <= 1'b0;
      cur_rd_q  <= DIR_READ;
      hist_q    <= '0;
    end else begin
      cur_vld_q <= cur_vld_d;
      cur_rd_q  <= cur_rd_d;
      hist_q    <= hist_d;
    end
  end

  assign hist = hist_q;
endmodule

// File: rtl/ofd_fetch_judge.sv
module ofd_fetch_judge
  import ofd_pkg::*;
(
  input  rw_hist_t hist,
  input  logic     cyc_mid,
  input  logic     bus_own,
  input  logic     rnw,
  output logic     safe_fetch
);
  logic hist_full;
  logic pattern_ok;

  always_comb begin
    hist_full  = hist.vld_old && hist.vld_new;
    pattern_ok = (hist.rd_old == DIR_READ) && (hist.rd_new == DIR_WRITE)
                 && (rnw == DIR_READ);
    safe_fetch = cyc_mid && bus_own && hist_full && pattern_ok;
  end
endmodule

// File: rtl/ofd_inject_ctrl.sv
module ofd_inject_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic safe_fetch,
  input  logic cyc_end,
  output logic drive,
  output logic injected
);
  logic arm_d_q;
  logic armed_q, armed_d;
  logic drive_q, drive_d;
  logic inj_q,   inj_d;
  logic arm_rise;
  logic fire;

  always_comb begin
    arm_rise = arm && !arm_d_q;
    fire     = armed_q && safe_fetch;
    armed_d  = armed_q;
    if (fire)          armed_d = 1'b0;
    else if (arm_rise) armed_d = 1'b1;
    drive_d = drive_q;
    if (cyc_end)   drive_d = 1'b0;
    else if (fire) drive_d = 1'b1;
    inj_d = cyc_end && drive_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_d_q <= 1'b0;
      armed_q <= 1'b0;
      drive_q <= 1'b0;
      inj_q   <= 1'b0;
    end else begin
      arm_d_q <= arm;
      armed_q <= armed_d;
      drive_q <= drive_d;
      inj_q   <= inj_d;
    end
  end

  assign drive    = drive_q;
  assign injected = inj_q;
endmodule

// File: rtl/ofd_brk_injector.sv
module ofd_brk_injector #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_mid,
  input  logic              cyc_end,
  input  logic              bus_own,
  input  logic              rnw,
  input  logic              arm,
  output logic [DATA_W-1:0] dbus_pd,
  output logic              injected
);
  import ofd_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  rw_hist_t               hist;
  logic                   safe_fetch;
  logic                   drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  ofd_rw_history u_hist (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cyc_mid (cyc_mid),
    .cyc_end (cyc_end),
    .bus_own (bus_own),
    .rnw     (rnw),
    .hist    (hist)
  );

  ofd_fetch_judge u_judge (
    .hist       (hist),
    .cyc_mid    (cyc_mid),
    .bus_own    (bus_own),
    .rnw        (rnw),
    .safe_fetch (safe_fetch)
  );

  ofd_inject_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .arm        (arm),
    .safe_fetch (safe_fetch),
    .cyc_end    (cyc_end),
    .drive      (drive),
    .injected   (injected)
  );

  for (genvar g = 0; g < DATA_W; g++) begin : g_pd
    assign dbus_pd[g] = drive;
  end
endmodule

// File: rtl/ofd_brk_injector_chk.sv
module ofd_brk_injector_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_mid,
  input logic              cyc_end,
  input logic              bus_own,
  input logic [DATA_W-1:0] dbus_pd,
  input logic              injected
);
  a_r2_all_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (|dbus_pd) |-> (&dbus_pd));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (dbus_pd == '0));

  a_r8_owned_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dbus_pd) |-> ($past(bus_own) && $past(cyc_mid)));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    injected |=> !injected);

  a_r9_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(injected) |-> ($past(|dbus_pd) && $past(cyc_end)));
endmodule

bind ofd_brk_injector ofd_brk_injector_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_mid  (cyc_mid),
  .cyc_end  (cyc_end),
  .bus_own  (bus_own),
  .dbus_pd  (dbus_pd),
  .injected (injected)
);

// File: tb/ofd_brk_injector_tb.sv
module ofd_brk_injector_tb;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n, cyc_mid, cyc_end, bus_own, rnw, arm;
  logic [DATA_W-1:0] dbus_pd;
  logic injected;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ofd_brk_injector #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_mid(cyc_mid), .cyc_end(cyc_end),
    .bus_own(bus_own), .rnw(rnw), .arm(arm),
    .dbus_pd(dbus_pd), .injected(injected)
  );

  typedef struct { bit fire; string tag; } exp_t;
  exp_t exp_q[$];
  event mid_ev, end_ev;

  // reference model of the history
  bit m_v_old, m_rd_old, m_v_new, m_rd_new, m_armed;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_v_old = 0; m_rd_old = 0; m_v_new = 0; m_rd_new = 0; m_armed = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; cyc_mid = 0; cyc_end = 0; bus_own = 1; rnw = 1; arm = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1;
    repeat (2) @(negedge clk);
    arm = 0;
    m_armed = 1;
  endtask

  // driver: one CPU cycle, expectation pushed to the scoreboard
  task automatic cpu_cycle(bit rd, bit own, string tag);
    exp_t e;
    e.fire = m_armed && own && rd && m_v_old && m_v_new && m_rd_old && !m_rd_new;
    e.tag  = tag;
    if (e.fire) m_armed = 0;
    if (own) begin
      m_v_old = m_v_new; m_rd_old = m_rd_new; m_v_new = 1; m_rd_new = rd;
    end
    exp_q.push_back(e);
    @(negedge clk) begin cyc_mid = 1; rnw = rd; bus_own = own; end
    @(negedge clk) cyc_mid = 0;
    -> mid_ev;
    @(negedge clk) cyc_end = 1;
    @(negedge clk) cyc_end = 0;
    -> end_ev;
    @(negedge clk);
  endtask

  // monitor
  initial forever begin
    @(mid_ev);
    if (exp_q.size() != 0) begin
      automatic logic [DATA_W-1:0] want = exp_q[0].fire ? '1 : '0;
      chk(dbus_pd == want, exp_q[0].tag, "pull-down in cycle", int'(dbus_pd), int'(want));
    end
  end

  initial forever begin
    @(end_ev);
    if (exp_q.size() != 0) begin
      automatic exp_t e = exp_q.pop_front();
      chk(injected == e.fire, e.tag, "injected pulse", int'(injected), int'(e.fire));
      chk(dbus_pd == '0, "R5", "pull-down after end", int'(dbus_pd), 0);
      @(negedge clk);
      chk(injected == 1'b0, "R9", "pulse width", int'(injected), 0);
    end
  end

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk(dbus_pd == '0, "R1", "pd after reset", int'(dbus_pd), 0);
    chk(injected == 1'b0, "R1", "inj after reset", int'(injected), 0);

    // R10: armed immediately, too little history
    do_arm();
    cpu_cycle(0, 1, "R10");
    cpu_cycle(1, 1, "R10");
    cpu_cycle(0, 1, "R10");
    cpu_cycle(1, 1, "R2");   // read-write-read with full history: injects

    // R6: no second injection without re-arming
    cpu_cycle(1, 1, "R6");
    cpu_cycle(0, 1, "R6");
    cpu_cycle(1, 1, "R6");

    // R3: double write then read
    do_arm();
    cpu_cycle(1, 1, "R3");
    cpu_cycle(0, 1, "R3");
    cpu_cycle(0, 1, "R3");
    cpu_cycle(1, 1, "R3");
    // R4: triple write then read
    cpu_cycle(0, 1, "R4");
    cpu_cycle(0, 1, "R4");
    cpu_cycle(0, 1, "R4");
    cpu_cycle(1, 1, "R4");
    cpu_cycle(1, 1, "R4");
    // R8: read-write-(not owned)-read still injects
    cpu_cycle(0, 1, "R8");
    cpu_cycle(1, 0, "R8");
    cpu_cycle(1, 0, "R8");
    cpu_cycle(1, 1, "R8");

    // R7: unarmed pattern ignored, arming after the write still fires
    cpu_cycle(1, 1, "R7");
    cpu_cycle(0, 1, "R7");
    cpu_cycle(1, 1, "R7");
    cpu_cycle(0, 1, "R7");
    do_arm();
    cpu_cycle(1, 1, "R7");

    // R2 again after a re-arm, different lead-in
    do_arm();
    cpu_cycle(0, 1, "R2");
    cpu_cycle(1, 1, "R2");
    cpu_cycle(0, 1, "R2");
    cpu_cycle(1, 1, "R2");

    // R1: reset while armed clears the arm
    do_arm();
    do_reset();
    cpu_cycle(1, 1, "R1");
    cpu_cycle(0, 1, "R1");
    cpu_cycle(1, 1, "R1");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule